// File: doc/BRIEF.md
# Byte-lane enabled SRAM front end

This block is a synchronous behavioural model of a 32-bit static memory whose four byte lanes are controlled separately. Each lane has its own active-low chip select and active-low write strobe, and one active-low output enable is shared by the read drivers. The controls are decoded into per-lane write pulses, per-lane read-drive enables and a standby flag. The block holds the storage array, which is organised as four byte-wide banks. It presents the data path as a separate write bus and read bus, with one drive-enable bit per byte lane in place of bidirectional pins.

A power-fail input overrides every other control. While it is high, no lane is written and no lane is driven. Read data comes from a register and is qualified by a per-lane valid flag. That flag rises a configurable number of clock edges after the address has settled. When the address moves, the previous word stays on the read bus until the next edge.

Byte lane n always maps to bits 8n+7 down to 8n of both data buses, and to bit n of every per-lane control and status vector.

Top module: `lane_sram_frontend`

## Requirements
- R1: The array holds 2**ADDR_W words of 32 bits (ADDR_W = 20 gives 1,048,576 words). A write with all four lanes enabled stores the full word, and reading that address later returns it.
- R2: Lane n is written at a rising clock edge exactly when ce_n[n]=0, we_n[n]=0 and pwr_fail=0. Lanes that are not written keep their stored byte.
- R3: A lane whose ce_n[n] is 1 is neither written nor driven, whatever its we_n[n] and oe_n are.
- R4: dout_oe[n] is 1, combinationally, exactly when ce_n[n]=0, oe_n=0, we_n[n]=1 and pwr_fail=0. With oe_n=1, no lane is driven and no lane becomes valid.
- R5: Writing takes priority over reading. While we_n[n]=0, dout_oe[n] is 0 even when oe_n=0, and the other lanes are unaffected.
- R6: standby is 1 when all four ce_n bits are 1 or when pwr_fail is 1. When all four ce_n bits are 1, dout_oe is all zero.
- R7: While pwr_fail=1, every other control is ignored. dout_oe is all zero, no lane is written, and no valid flag rises at the next edge.
- R8: dout_vld[n] is registered. It is 1 after an edge only if lane n was being read at that edge and the address had been sampled unchanged on RD_LAT consecutive edges. It is 0 before the first such edge.
- R9: When the address changes while a lane is still enabled, dout and dout_vld keep their previous values until the next rising edge. After that edge they reflect the new address, subject to R8.
- R10: A synchronous active-low reset clears dout, dout_vld and the address-age state, but it leaves the storage array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and read registers update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read path |
| pwr_fail | input | 1 | Forces every lane off while high |
| addr | input | ADDR_W | Word address |
| ce_n | input | 4 | Per-lane chip select, active low |
| we_n | input | 4 | Per-lane write strobe, active low |
| oe_n | input | 1 | Shared read output enable, active low |
| din | input | 32 | Write data, byte lane n on bits 8n+7:8n |
| dout | output | 32 | Registered read data |
| dout_oe | output | 4 | Per-lane read drive enable |
| dout_vld | output | 4 | Per-lane read data valid |
| standby | output | 1 | Device deselected or powered off |

## Verification
Full-word writes and reads at the lowest and highest addresses show whether the banks and the address decode line up. A single-lane write that follows a full word shows whether the untouched lanes keep their bytes. Mixed selects, such as a chip-select-high lane with its write strobe low, a write strobe low while output enable is active, and alternate lanes selected, separate the decode terms from one another. The power-fail pattern and the all-deselected pattern check the overrides. An address change sampled just before the next edge, and a reset during an active read that is followed by a read-back, separate the hold behaviour and the reset that spares the array.

// File: rtl/lane_sram_pkg.sv
`timescale 1ns/1ps
package lane_sram_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  // A lane accepts write data when it is selected and strobed, and power is good.
  function automatic logic lane_writes(input logic pf, input logic cs_n, input logic wr_n);
    return !pf && !cs_n && !wr_n;
  endfunction

  // A lane drives read data when selected, output enabled, not writing, power good.
  function automatic logic lane_drives(input logic pf, input logic cs_n,
                                       input logic rd_oe_n, input logic wr_n);
    return !pf && !cs_n && !rd_oe_n && wr_n;
  endfunction

  // The age of the sampled address in edges, saturating at lim.
  function automatic int unsigned age_step(input int unsigned age, input int unsigned lim,
                                           input logic same);
    if (!same) return 1;
    return (age >= lim) ? lim : age + 1;
  endfunction
endpackage

// File: rtl/lane_sram_decode.sv
`timescale 1ns/1ps
module lane_sram_decode
  import lane_sram_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  logic             pwr_fail,
  input  logic [NLANE-1:0] ce_n,
  input  logic [NLANE-1:0] we_n,
  input  logic             oe_n,
  output logic [NLANE-1:0] wr_stb,
  output logic [NLANE-1:0] rd_en,
  output logic             standby
);
  for (genvar n = 0; n < NLANE; n++) begin : g_lane
    assign wr_stb[n] = lane_writes(pwr_fail, ce_n[n], we_n[n]);
    assign rd_en[n]  = lane_drives(pwr_fail, ce_n[n], oe_n, we_n[n]);
  end

  assign standby = pwr_fail | (&ce_n);
endmodule

// File: rtl/lane_sram_bytelane.sv
`timescale 1ns/1ps
module lane_sram_bytelane #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] bank [DEPTH];
  logic [BYTE_W-1:0] rdata_q;

  // The array carries no reset; it must survive a reset of the read path.
  always_ff @(posedge clk) begin
    if (wr) bank[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bank[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lane_sram_rdpipe.sv
`timescale 1ns/1ps
module lane_sram_rdpipe
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RD_LAT = 1,
  parameter int NLANE  = LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NLANE-1:0]  rd_en,
  output logic [NLANE-1:0]  vld
);
  localparam int AGE_W = $clog2(RD_LAT + 1);

  logic [ADDR_W-1:0] addr_q;
  logic              primed_q;
  logic [AGE_W-1:0]  age_q;
  logic [AGE_W-1:0]  age_d;
  logic              addr_same;
  logic              age_reached;
  logic [NLANE-1:0]  vld_q;

  assign addr_same   = primed_q && (addr == addr_q);
  assign age_d       = AGE_W'(age_step(32'(age_q), 32'(RD_LAT), addr_same));
  assign age_reached = 32'(age_d) >= 32'(RD_LAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      primed_q <= 1'b0;
      age_q    <= '0;
      vld_q    <= '0;
    end else begin
      addr_q   <= addr;
      primed_q <= 1'b1;
      age_q    <= age_d;
      vld_q    <= rd_en & {NLANE{age_reached}};
    end
  end

  assign vld = vld_q;
endmodule

// File: rtl/lane_sram_frontend.sv
`timescale 1ns/1ps
module lane_sram_frontend
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  ce_n,
  input  logic [LANES-1:0]  we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dout_oe,
  output logic [LANES-1:0]  dout_vld,
  output logic              standby
);
  logic [LANES-1:0] wr_stb;
  logic [LANES-1:0] rd_en;

  lane_sram_decode #(.NLANE(LANES)) u_decode (
    .pwr_fail (pwr_fail),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .wr_stb   (wr_stb),
    .rd_en    (rd_en),
    .standby  (standby)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_bank
    lane_sram_bytelane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_stb[n]),
      .addr  (addr),
      .wdata (din[n*BYTE_W +: BYTE_W]),
      .rdata (dout[n*BYTE_W +: BYTE_W])
    );
  end

  lane_sram_rdpipe #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT), .NLANE(LANES)) u_rdpipe (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .rd_en (rd_en),
    .vld   (dout_vld)
  );

  assign dout_oe = rd_en;
endmodule

// File: rtl/lane_sram_chk.sv
`timescale 1ns/1ps
module lane_sram_chk #(
  parameter int NLANE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_fail,
  input logic [NLANE-1:0] ce_n,
  input logic [NLANE-1:0] we_n,
  input logic [NLANE-1:0] wr_stb,
  input logic [NLANE-1:0] dout_oe,
  input logic [NLANE-1:0] dout_vld,
  input logic             standby
);
  for (genvar n = 0; n < NLANE; n++) begin : g_lane
    assert_deselected_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n[n] |-> (!wr_stb[n] && !dout_oe[n]));
    assert_write_blocks_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n[n] |-> !dout_oe[n]);
    assert_valid_follows_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld[n] |-> $past(dout_oe[n]));
  end

  assert_all_deselect_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&ce_n) |-> (standby && dout_oe == '0));
  assert_power_fail_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (wr_stb == '0 && dout_oe == '0 && standby));
  assert_power_fail_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (dout_vld == '0));
endmodule

bind lane_sram_frontend lane_sram_chk #(.NLANE(4)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_fail (pwr_fail),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .wr_stb   (wr_stb),
  .dout_oe  (dout_oe),
  .dout_vld (dout_vld),
  .standby  (standby)
);

// File: tb/lane_sram_frontend_tb.sv
`timescale 1ns/1ps
module lane_sram_frontend_tb_top;
  localparam int AW  = 8;
  localparam int LAT = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwr_fail;
  logic [AW-1:0] addr;
  logic [3:0]    ce_n, we_n;
  logic          oe_n;
  logic [31:0]   din;
  logic [31:0]   dout;
  logic [3:0]    dout_oe, dout_vld;
  logic          standby;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [31:0] model [int];

  typedef struct {
    int          due;
    logic [3:0]  mask;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_sram_frontend #(.ADDR_W(AW), .RD_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .addr(addr), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_oe(dout_oe),
    .dout_vld(dout_vld), .standby(standby)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [31:0] peek(input int a);
    return model.exists(a) ? model[a] : 32'h0;
  endfunction

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic idle();
    ce_n = 4'hF; we_n = 4'hF; oe_n = 1'b1; pwr_fail = 1'b0;
  endtask

  // Drive one write cycle; the model commits the lanes that are expected to be written.
  task automatic wr(input int a, input logic [3:0] m, input logic [31:0] d);
    step();
    addr = AW'(a); ce_n = ~m; we_n = ~m; oe_n = 1'b1; din = d;
    @(posedge clk);
    model[a] = (peek(a) & ~lanes(m)) | (d & lanes(m));
    step();
    idle();
  endtask

  // Drive a read and push the expected result to the scoreboard.
  task automatic rd(input int a, input logic [3:0] m, input string req);
    exp_t e;
    step();
    addr = AW'(a); ce_n = ~m; we_n = 4'hF; oe_n = 1'b0;
    e.due = cyc + LAT; e.mask = m; e.data = peek(a); e.req = req;
    q.push_back(e);
    repeat (LAT) @(posedge clk);
    step();
    idle();
  endtask

  // Monitor: compares due items at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.due == cyc, e.req, 32'(cyc), 32'(e.due));
      check(dout_vld == e.mask, e.req, 32'(dout_vld), 32'(e.mask));
      check((dout & lanes(e.mask)) == (e.data & lanes(e.mask)), e.req,
            dout & lanes(e.mask), e.data & lanes(e.mask));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; addr = '0; din = '0; idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 R6: reset state
    check(dout_vld == 4'h0, "R10 reset valid", 32'(dout_vld), 0);
    check(dout == 32'h0, "R10 reset data", dout, 0);
    check(dout_oe == 4'h0 && standby, "R6 reset standby", {27'h0, standby, dout_oe}, 32'h10);
    #0.5 rst_n = 1'b1;

    // R1: full words at low and high addresses
    wr(5, 4'hF, 32'hA1B2C3D4);
    wr(255, 4'hF, 32'h0F1E2D3C);
    rd(5, 4'hF, "R1 word low");
    rd(255, 4'hF, "R1 word high");

    // R2: single-lane write keeps the other lanes
    wr(5, 4'b0100, 32'h5A5A5A5A);
    check(peek(5) == 32'hA15AC3D4, "R2 model", peek(5), 32'hA15AC3D4);
    rd(5, 4'hF, "R2 byte write");

    // R3: lane 0 strobed with its select high: no write, no drive
    step();
    addr = 8'd5; ce_n = 4'b0001; we_n = 4'b1110; oe_n = 1'b1; din = 32'hFFFFFFFF;
    #0.5 check(dout_oe == 4'h0, "R3 no drive", 32'(dout_oe), 0);
    step(); idle();
    rd(5, 4'hF, "R3 no write");

    // R4: alternate lanes selected
    step();
    addr = 8'd5; ce_n = 4'b0101; we_n = 4'hF; oe_n = 1'b0;
    #0.5 check(dout_oe == 4'b1010, "R4 partial drive", 32'(dout_oe), 32'hA);
    step(); idle();
    rd(255, 4'b1010, "R4 partial read");

    // R4: output enable high blocks drive and valid
    step();
    addr = 8'd5; ce_n = 4'h0; we_n = 4'hF; oe_n = 1'b1;
    #0.5 check(dout_oe == 4'h0, "R4 oe high drive", 32'(dout_oe), 0);
    step();
    check(dout_vld == 4'h0, "R4 oe high valid", 32'(dout_vld), 0);
    idle();

    // R5: lane 1 writing while output enabled
    step();
    addr = 8'd5; ce_n = 4'h0; we_n = 4'b1101; oe_n = 1'b0; din = 32'h00007700;
    #0.5 check(dout_oe == 4'b1101, "R5 write priority", 32'(dout_oe), 32'hD);
    @(posedge clk);
    model[5] = (peek(5) & 32'hFFFF00FF) | 32'h00007700;
    step(); idle();
    rd(5, 4'hF, "R5 lane written");

    // R6: all deselected with output enabled
    step();
    ce_n = 4'hF; we_n = 4'h0; oe_n = 1'b0;
    #0.5 check(standby && dout_oe == 4'h0, "R6 deselect", {27'h0, standby, dout_oe}, 32'h10);
    step(); idle();

    // R7: power fail ignores a full write with output enabled
    step();
    pwr_fail = 1'b1; addr = 8'd5; ce_n = 4'h0; we_n = 4'h0; oe_n = 1'b0; din = 32'hDEADBEEF;
    #0.5 check(standby && dout_oe == 4'h0, "R7 power fail drive", {27'h0, standby, dout_oe}, 32'h10);
    step();
    check(dout_vld == 4'h0, "R7 power fail valid", 32'(dout_vld), 0);
    idle();
    rd(5, 4'hF, "R7 no write");

    // R8: valid stays low before the first edge of a read
    step();
    addr = 8'd255; ce_n = 4'h0; we_n = 4'hF; oe_n = 1'b0;
    #0.5 check(dout_vld == 4'h0, "R8 before edge", 32'(dout_vld), 0);
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    check(dout_vld == 4'hF && dout == peek(255), "R8 after latency", dout, peek(255));

    // R9: address change holds old data until the next edge
    #0.5 held = dout;
    addr = 8'd5;
    #0.5 check(dout == held && dout_vld == 4'hF, "R9 hold", dout, held);
    @(negedge clk);
    check(dout_vld == ((LAT == 1) ? 4'hF : 4'h0), "R9 valid after edge", 32'(dout_vld),
          (LAT == 1) ? 32'hF : 32'h0);
    if (LAT == 1) check(dout == peek(5), "R9 new data", dout, peek(5));

    // R10: reset during a read clears the read path but not the array
    #0.5 rst_n = 1'b0;
    @(negedge clk);
    check(dout_vld == 4'h0 && dout == 32'h0, "R10 reset mid read", dout, 0);
    #0.5 rst_n = 1'b1; idle();
    rd(5, 4'hF, "R10 array kept");
    rd(255, 4'hF, "R10 array kept high");

    step(); step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule